// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block marks when external events happen. It copies the value of a free-running counter into a capture register whenever the chosen input shows an edge of the chosen polarity. The counter is not part of the block: its value arrives on an input port. The event input is one of two sources, a capture pin or an alternate comparator line, and a select bit chooses between them. The chosen level passes through a two-flop synchroniser. After that it may go through an optional noise filter, which accepts a new level only when four consecutive system-clock samples agree. An edge detector with programmable polarity follows.

Every capture sets a flag in the same cycle as the register update. Software clears the flag by writing a one, and an interrupt acknowledge also clears it. The flag and an enable bit together raise an interrupt. Software reaches the 16-bit register over an 8-bit bus through one shared temporary high byte:
- A low-byte read loads the temporary byte with the high half of the register.
- A high-byte read returns the temporary byte.

When the counter uses the capture register as its TOP, the block stops capturing. In that mode software may write the register: first the high byte into the temporary byte, then the low byte, which commits both halves.

Top module: `edge_timestamp`

## Requirements
- R1: After reset the capture register, the temporary byte, `cap_flag` and `irq` are all 0.
- R2: With the filter off, suppose the selected input changes before clock edge E0 and the change matches the polarity. Then at E2 the capture register takes the `count_val` present between E1 and E2, and `cap_flag` is set at that same edge. `edge_rise`=1 selects rising edges and 0 selects falling edges. An edge of the other polarity captures nothing.
- R3: With `filt_en`=1 the same capture happens at E6, exactly four cycles later. A level held for fewer than four consecutive samples never reaches the edge detector. A level held for exactly four samples does reach it.
- R4: `src_alt`=0 selects `pin_in` and `src_alt`=1 selects `cmp_in`. The unselected input has no effect. Switching `src_alt` while the two inputs differ acts as an edge on the selected level.
- R5: `flag_clr` or `irq_ack` clears `cap_flag` one cycle later. A capture in the same cycle wins over the clear. `irq` is `cap_flag` AND `irq_en`.
- R6: A new capture overwrites the capture register even if the old value was never read.
- R7: `bus_addr`=0 is the low byte and 1 is the high byte. A read at address 0 returns the low byte and loads the temporary byte with the high byte. A read at address 1 returns the temporary byte, which stays unchanged until the next low-byte read.
- R8: With `top_mode`=1, a write at address 1 loads the temporary byte, and a write at address 0 stores {temporary, `bus_wdata`} into the capture register. With `top_mode`=0 all writes are ignored.
- R9: While `top_mode`=1 no edge causes a capture and `cap_flag` does not get set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Capture pin, asynchronous |
| cmp_in | input | 1 | Alternate comparator line, asynchronous |
| src_alt | input | 1 | 1 selects `cmp_in`, 0 selects `pin_in` |
| filt_en | input | 1 | Enables the four-sample noise filter |
| edge_rise | input | 1 | 1 = rising-edge trigger, 0 = falling-edge trigger |
| top_mode | input | 1 | Capture register defines the counter TOP: no captures, writes allowed |
| count_val | input | 16 | Running counter value |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 1 | 0 = low byte, 1 = high byte |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data (combinational from `bus_addr`) |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq_en | input | 1 | Interrupt enable |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures capture latency through the captured value itself. If a design is one cycle short or long in the synchroniser, or in the four-sample filter window, it stores a timestamp that is off by one. The filter is probed with a three-sample glitch and with an exactly four-sample pulse. A filter that waits too long misses the pulse, and a filter that is too lenient records a spurious capture. Other cases the bench drives:
- Captures on the opposite polarity.
- Edges produced by switching the source.
- Overwrite of an unread value.
- Temporary-byte isolation across a fresh capture: a design that reads the high byte straight from the register returns the new value instead of the latched one.
- Ignored writes outside TOP mode.
- Edges while in TOP mode.

// File: rtl/edge_timestamp_pkg.sv
package edge_timestamp_pkg;

  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } byte_sel_e;

  function automatic logic pick_source(input logic use_alt, input logic pin, input logic cmp);
    return use_alt ? cmp : pin;
  endfunction

  function automatic logic edge_hit(input logic prev, input logic cur, input logic rise);
    return rise ? (!prev && cur) : (prev && !cur);
  endfunction

endpackage

// File: rtl/ets_sync.sv
module ets_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ets_filter.sv
module ets_filter #(
  parameter int SAMPLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  localparam int HIST_W = SAMPLES - 1;

  logic [HIST_W-1:0]  hist;
  logic [SAMPLES-1:0] window;
  logic               agree;
  logic               filt_q;

  assign window = {hist, d};
  assign agree  = (&window) | (~|window);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= '0;
      filt_q <= 1'b0;
    end else begin
      hist <= window[SAMPLES-2:0];
      if (agree) filt_q <= d;
    end
  end

  assign q = en ? filt_q : d;

  // R3: the filtered level moves only after a full window of agreeing samples
  a_r3_filter_agree: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> $past(agree));
endmodule

// File: rtl/ets_edge.sv
module ets_edge
  import edge_timestamp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise,
  input  logic arm,
  output logic hit
);
  logic prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= 1'b0;
    else        prev_lvl <= lvl;
  end

  assign hit = arm && edge_hit(prev_lvl, lvl, rise);
endmodule

// File: rtl/ets_capreg.sv
module ets_capreg
  import edge_timestamp_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  logic [2*BUS_W-1:0] count_val,
  input  logic               top_mode,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic               bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic               flag_clr,
  input  logic               irq_ack,
  output logic               flag
);
  localparam int CNT_W = 2 * BUS_W;

  logic [CNT_W-1:0] cap_q;
  logic [BUS_W-1:0] temp_q;
  logic             lo_read, hi_write, lo_write;

  assign lo_read  = bus_rd && (bus_addr == SEL_LO);
  assign hi_write = bus_wr && top_mode && (bus_addr == SEL_HI);
  assign lo_write = bus_wr && top_mode && (bus_addr == SEL_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      temp_q <= '0;
      flag   <= 1'b0;
    end else begin
      if (hit)           cap_q <= count_val;
      else if (lo_write) cap_q <= {temp_q, bus_wdata};
      if (lo_read)       temp_q <= cap_q[CNT_W-1:BUS_W];
      else if (hi_write) temp_q <= bus_wdata;
      if (hit)                      flag <= 1'b1;
      else if (flag_clr || irq_ack) flag <= 1'b0;
    end
  end

  assign bus_rdata = (bus_addr == SEL_LO) ? cap_q[BUS_W-1:0] : temp_q;

  // R2: a capture stores the counter value of the hit cycle
  a_r2_cap_value: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cap_q == $past(count_val));
  // R5: flag set with capture, cleared by clear or ack otherwise
  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_clr || irq_ack) && !hit) |=> !flag);
  // R6 / R8: register changes only through capture or a TOP-mode low write
  a_r6_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !lo_write) |=> $stable(cap_q));
  // R7: low-byte read latches the high half
  a_r7_temp_load: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_read && !bus_wr) |=> temp_q == $past(cap_q[CNT_W-1:BUS_W]));
endmodule

// File: rtl/edge_timestamp.sv
module edge_timestamp
  import edge_timestamp_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int SYNC_LEN  = 2,
  parameter int FILT_LEN  = 4,
  localparam int CNT_W    = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             cmp_in,
  input  logic             src_alt,
  input  logic             filt_en,
  input  logic             edge_rise,
  input  logic             top_mode,
  input  logic [CNT_W-1:0] count_val,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             flag_clr,
  input  logic             irq_ack,
  input  logic             irq_en,
  output logic             cap_flag,
  output logic             irq
);
  logic src_raw;
  logic src_sync;
  logic det_lvl;
  logic cap_hit;

  assign src_raw = pick_source(src_alt, pin_in, cmp_in);

  ets_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_raw), .q(src_sync)
  );

  ets_filter #(.SAMPLES(FILT_LEN)) u_filter (
    .clk(clk), .rst_n(rst_n), .en(filt_en), .d(src_sync), .q(det_lvl)
  );

  ets_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(det_lvl), .rise(edge_rise),
    .arm(!top_mode), .hit(cap_hit)
  );

  ets_capreg #(.BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .hit(cap_hit), .count_val(count_val),
    .top_mode(top_mode), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag_clr(flag_clr), .irq_ack(irq_ack), .flag(cap_flag)
  );

  assign irq = cap_flag && irq_en;

  // R9: in TOP mode a clear flag stays clear
  a_r9_top_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (top_mode && !cap_flag) |=> !cap_flag);
  // R5: interrupt follows flag and enable
  a_r5_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cap_flag && irq_en));
endmodule

// File: tb/edge_timestamp_tb.sv
module edge_timestamp_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pin_in, cmp_in, src_alt, filt_en, edge_rise, top_mode;
  logic        bus_rd, bus_wr, bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        flag_clr, irq_ack, irq_en, cap_flag, irq;
  logic [15:0] cnt = 16'h0000;
  logic [15:0] base;
  logic [15:0] count_val;

  int checks = 0;
  int fails  = 0;
  logic [15:0] expq[$];
  logic        flag_d = 1'b0;
  bit          done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 16'd1;
  assign count_val = cnt + base;

  edge_timestamp u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cmp_in(cmp_in),
    .src_alt(src_alt), .filt_en(filt_en), .edge_rise(edge_rise),
    .top_mode(top_mode), .count_val(count_val), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .flag_clr(flag_clr), .irq_ack(irq_ack),
    .irq_en(irq_en), .cap_flag(cap_flag), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: each flag rise pops one expected timestamp
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && cap_flag === 1'b1 && flag_d === 1'b0) begin
        if (expq.size() == 0) chk("R2/R3 unexpected capture", 32'(cap_flag), 32'd0);
        else chk("R2/R3 capture timing", 32'(count_val - 16'd1), 32'(expq.pop_front()));
      end
      flag_d = cap_flag;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input bit use_cmp, input logic v, input int lat,
                       input bit push, output logic [15:0] e);
    @(negedge clk);
    if (use_cmp) cmp_in = v; else pin_in = v;
    e = count_val + 16'(lat);
    if (push) expq.push_back(e);
  endtask

  task automatic rd_byte(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr_byte(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_word(output logic [15:0] w);
    logic [7:0] lo, hi;
    rd_byte(1'b0, lo);
    rd_byte(1'b1, hi);
    w = {hi, lo};
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-R actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] e, e2, w;
    logic [7:0]  b;
    rst_n = 1'b0; pin_in = 0; cmp_in = 0; src_alt = 0; filt_en = 0;
    edge_rise = 1; top_mode = 0; bus_rd = 0; bus_wr = 0; bus_addr = 0;
    bus_wdata = 0; flag_clr = 0; irq_ack = 0; irq_en = 0; base = 16'h0000;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 flag", 32'(cap_flag), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    rd_word(w);
    chk("R1 capture register", 32'(w), 32'd0);

    // R2 rising capture, unfiltered
    drive(0, 1'b1, 2, 1, e);
    idle(6);
    chk("R2 flag set", 32'(cap_flag), 32'd1);
    rd_word(w);
    chk("R2 rising value", 32'(w), 32'(e));
    clear_flag();
    chk("R5 write-one clear", 32'(cap_flag), 32'd0);

    // R2 opposite polarity ignored
    drive(0, 1'b0, 2, 0, e);
    idle(8);
    chk("R2 falling ignored in rising mode", 32'(cap_flag), 32'd0);

    // R2 falling mode
    edge_rise = 1'b0;
    drive(0, 1'b1, 2, 0, e);
    idle(8);
    chk("R2 rising ignored in falling mode", 32'(cap_flag), 32'd0);
    drive(0, 1'b0, 2, 1, e);
    idle(6);
    rd_word(w);
    chk("R2 falling value", 32'(w), 32'(e));
    clear_flag();

    // R3 filter latency
    edge_rise = 1'b1; filt_en = 1'b1;
    idle(2);
    drive(0, 1'b1, 6, 1, e);
    idle(10);
    rd_word(w);
    chk("R3 filtered latency", 32'(w), 32'(e));
    clear_flag();

    // R3 three-sample glitch rejected
    drive(0, 1'b0, 0, 0, e);
    idle(2);
    drive(0, 1'b1, 0, 0, e);
    idle(12);
    chk("R3 short glitch rejected", 32'(cap_flag), 32'd0);

    // R3 exactly four samples accepted
    drive(0, 1'b0, 0, 0, e);
    idle(3);
    drive(0, 1'b1, 6, 1, e);
    idle(12);
    chk("R3 four-sample pulse flag", 32'(cap_flag), 32'd1);
    rd_word(w);
    chk("R3 four-sample pulse value", 32'(w), 32'(e));
    clear_flag();
    filt_en = 1'b0;
    idle(2);

    // R4 source select
    src_alt = 1'b1;
    idle(6);
    drive(0, 1'b0, 0, 0, e);
    idle(3);
    drive(0, 1'b1, 0, 0, e);
    idle(6);
    chk("R4 unselected pin ignored", 32'(cap_flag), 32'd0);
    drive(1, 1'b1, 2, 1, e);
    idle(6);
    rd_word(w);
    chk("R4 comparator capture", 32'(w), 32'(e));
    clear_flag();
    drive(0, 1'b0, 0, 0, e);
    @(negedge clk); src_alt = 1'b0;
    idle(6);
    chk("R4 switch to low source no rise", 32'(cap_flag), 32'd0);
    @(negedge clk);
    src_alt = 1'b1;
    e = count_val + 16'd2;
    expq.push_back(e);
    idle(6);
    rd_word(w);
    chk("R4 source switch capture", 32'(w), 32'(e));
    clear_flag();
    @(negedge clk); cmp_in = 1'b0;
    idle(4);
    @(negedge clk); src_alt = 1'b0;
    idle(4);

    // R5 interrupt and acknowledge
    irq_en = 1'b1;
    drive(0, 1'b1, 2, 1, e);
    idle(6);
    chk("R5 irq raised", 32'(irq), 32'd1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R5 ack clears flag", 32'(cap_flag), 32'd0);
    chk("R5 ack drops irq", 32'(irq), 32'd0);
    irq_en = 1'b0;

    // R6 overwrite without read
    base = 16'h1200;
    edge_rise = 1'b0;
    drive(0, 1'b0, 2, 1, e);
    idle(6);
    edge_rise = 1'b1;
    base = 16'h5600;
    drive(0, 1'b1, 2, 0, e2);
    idle(6);
    chk("R5 irq masked", 32'(irq), 32'd0);
    rd_word(w);
    chk("R6 overwrite keeps newest", 32'(w), 32'(e2));
    clear_flag();

    // R7 temporary byte isolation
    rd_byte(1'b0, b);
    base = 16'hA700;
    edge_rise = 1'b0;
    drive(0, 1'b0, 2, 1, e);
    idle(6);
    rd_byte(1'b1, b);
    chk("R7 high read returns latched byte", 32'(b), 32'(e2[15:8]));
    rd_word(w);
    chk("R7 fresh word", 32'(w), 32'(e));
    clear_flag();

    // R8 writes ignored outside TOP mode
    wr_byte(1'b1, 8'h77);
    wr_byte(1'b0, 8'h88);
    rd_word(w);
    chk("R8 write ignored outside TOP", 32'(w), 32'(e));

    // R9 no captures in TOP mode
    top_mode = 1'b1;
    drive(0, 1'b1, 0, 0, e2);
    idle(5);
    drive(0, 1'b0, 0, 0, e2);
    idle(8);
    chk("R9 no capture in TOP mode", 32'(cap_flag), 32'd0);

    // R8 TOP-mode write
    wr_byte(1'b1, 8'hA5);
    wr_byte(1'b0, 8'h5A);
    rd_word(w);
    chk("R8 TOP write commits both bytes", 32'(w), 32'hA55A);
    top_mode = 1'b0;
    idle(4);

    chk("R2/R3 all expected captures seen", 32'(expq.size()), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule